// File: doc/BRIEF.md
# Speculative Memory Request Gate

This block stands between the issue stage of an out-of-order core and the memory port. For every memory request it decides one of three things. The request goes to memory in the same cycle. A fault is reported to the core in the same cycle. Or the request is parked in a small hold queue until the branch it depends on is resolved. A request is parked when sending it early could cause a side effect that cannot be undone. Stores are parked. So is any access to a page that the translation lookup marks as uncached or volatile, and so is a load that would fault. Ordinary cached loads go ahead even on a speculative path.

Branch outcomes arrive as resolve events that carry a branch tag and a confirm-or-squash bit. A confirm makes the parked requests under that tag eligible for release. They leave one per cycle, oldest first by sequence number. Releases that were held for a fault come out on the fault port and not on the memory port. A squash deletes every parked request under that tag at once, and none of them ever reaches memory. Accesses to volatile pages reach memory strictly in sequence order, including a non-speculative volatile access that arrives while older ones are still parked.

Top module: `spec_issue_gate`

## Requirements
- R1: A request with `req_spec`=1 and `req_store`=1 never appears on `mem_valid` in its issue cycle. It is parked until its tag is confirmed, and in the cycle after the confirm it appears with `mem_store`=1.
- R2: A speculative access with `req_uncached`=1 is parked and does not reach the memory port while its branch is unresolved.
- R3: A confirm (`res_squash`=0) for a tag releases every parked request under that tag. A squash (`res_squash`=1) discards them, and no memory or fault output is ever produced for them.
- R4: Parked requests do not block other traffic. A speculative cached load with `req_xlate_hit`=1 to a nonzero page, and any non-speculative non-faulting request with no older volatile access parked, appear on `mem_valid` in the same cycle they are issued.
- R5: Uncached, non-faulting accesses reach memory in ascending `req_seq` order. If any such access is parked, a later non-speculative uncached request is parked as already confirmed and leaves after it.
- R6: A load faults when `req_xlate_hit`=0 or when address bits [31:12] are all zero (page zero). A speculative faulting load is parked. On confirm it leaves on `flt_valid` with its `flt_seq`, and never on `mem_valid`. A non-speculative faulting load raises `flt_valid` in the same cycle.
- R7: The hold queue has 8 entries. `req_ready` is 0 exactly while all 8 entries are occupied, and it returns to 1 once an entry is released.
- R8: At most one parked request is released per cycle, oldest `req_seq` first. A same-cycle pass-through has priority on the port it uses.
- R9: A squash removes, in one cycle, every unconfirmed entry with a matching tag. Entries under other tags are kept and are released on their own confirm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A memory request is offered |
| req_ready | output | 1 | The gate can accept a request (queue not full) |
| req_spec | input | 1 | The request is on an unresolved branch path |
| req_tag | input | 3 | Tag of the controlling branch |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Request address |
| req_uncached | input | 1 | The page attribute marks the target uncached/volatile |
| req_xlate_hit | input | 1 | The translation lookup found the page |
| req_seq | input | 8 | Program-order sequence number (wraps) |
| res_valid | input | 1 | A branch resolve event is present |
| res_squash | input | 1 | 1 = squash, 0 = confirm |
| res_tag | input | 3 | Tag of the resolved branch |
| mem_valid | output | 1 | A request goes to memory this cycle |
| mem_store | output | 1 | The memory request is a store |
| mem_addr | output | 32 | Memory request address |
| mem_seq | output | 8 | Sequence number of the memory request |
| flt_valid | output | 1 | A fault is reported to the core this cycle |
| flt_seq | output | 8 | Sequence number of the faulting load |

## Verification
Several properties are checked on every cycle. No speculative store or uncached access is forwarded directly. The queue never takes a request while full. At most one entry leaves per cycle. A pass-through and a release never collide on the memory port. Volatile releases never go backwards in sequence. No unconfirmed entry of a squashed tag survives the squash. Only the bench scenarios can show the end-to-end effects. These are that a confirmed entry really comes out with the right sequence number and port, that a squashed entry never appears at all, that release follows age order across tags, and that `req_ready` recovers after a full queue drains.

// File: rtl/sig_pkg.sv
package sig_pkg;

    typedef enum logic [1:0] {
        ACT_PASS  = 2'd0,
        ACT_FAULT = 2'd1,
        ACT_HOLD  = 2'd2
    } gate_act_e;

    typedef struct packed {
        logic store;
        logic vol;
        logic flt;
    } req_flags_t;

endpackage

// File: rtl/sig_classify.sv
module sig_classify
    import sig_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PAGE_BITS = 12
) (
    input  logic              spec,
    input  logic              store,
    input  logic              uncached,
    input  logic              xlate_hit,
    input  logic [ADDR_W-1:0] addr,
    input  logic              vol_pending,
    output gate_act_e         act,
    output req_flags_t        flags
);

    logic page_zero;

    always_comb begin
        page_zero   = (addr[ADDR_W-1:PAGE_BITS] == '0);
        flags.store = store;
        flags.flt   = !store && (!xlate_hit || page_zero);
        flags.vol   = uncached && !flags.flt;
        if (spec) begin
            act = (store || uncached || flags.flt) ? ACT_HOLD : ACT_PASS;
        end else if (flags.flt) begin
            act = ACT_FAULT;
        end else if (flags.vol && vol_pending) begin
            act = ACT_HOLD;
        end else begin
            act = ACT_PASS;
        end
    end

endmodule

// File: rtl/sig_oldest_pick.sv
module sig_oldest_pick #(
    parameter int unsigned N     = 8,
    parameter int unsigned SEQ_W = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N-1:0]            elig,
    input  logic [N-1:0][SEQ_W-1:0] seq,
    output logic                    found,
    output logic [IDX_W-1:0]        idx,
    output logic [N-1:0]            onehot
);

    function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction

    always_comb begin
        found  = 1'b0;
        idx    = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!found || older(seq[i], seq[idx]))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
        onehot = '0;
        if (found) onehot[idx] = 1'b1;
    end

endmodule

// File: rtl/sig_hold_queue.sv
module sig_hold_queue
    import sig_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned TAG_W  = 3,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SEQ_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              push_conf,
    input  req_flags_t        push_flags,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic              res_valid,
    input  logic              res_squash,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic              mem_busy,
    input  logic              flt_busy,
    output logic              full,
    output logic              vol_pending,
    output logic              rel_mem,
    output logic              rel_flt,
    output logic              rel_store,
    output logic [ADDR_W-1:0] rel_addr,
    output logic [SEQ_W-1:0]  rel_seq
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0]             conf;
        logic [DEPTH-1:0]             st;
        logic [DEPTH-1:0]             vol;
        logic [DEPTH-1:0]             flt;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][SEQ_W-1:0]  seq;
    } hq_state_t;

    hq_state_t          q, d;
    logic [DEPTH-1:0]   vol_block, elig, rel_onehot;
    logic               found, free_found, tag_hit;
    logic [IDX_W-1:0]   sel, free_idx;

    function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vol_block[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (q.vld[j] && q.vol[j] && older(q.seq[j], q.seq[i])) vol_block[i] = 1'b1;
            end
            elig[i] = q.vld[i] && q.conf[i] && !(q.vol[i] && vol_block[i])
                      && (q.flt[i] ? !flt_busy : !mem_busy);
        end
    end

    sig_oldest_pick #(.N(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_pick (
        .elig   (elig),
        .seq    (q.seq),
        .found  (found),
        .idx    (sel),
        .onehot (rel_onehot)
    );

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!q.vld[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        d       = q;
        tag_hit = res_valid && (res_tag == push_tag);
        if (found) d.vld[sel] = 1'b0;
        if (res_valid) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (q.vld[i] && !q.conf[i] && q.tag[i] == res_tag) begin
                    if (res_squash) d.vld[i]  = 1'b0;
                    else            d.conf[i] = 1'b1;
                end
            end
        end
        if (push && free_found && !(tag_hit && res_squash && !push_conf)) begin
            d.vld[free_idx]  = 1'b1;
            d.conf[free_idx] = push_conf || (tag_hit && !res_squash);
            d.st[free_idx]   = push_flags.store;
            d.vol[free_idx]  = push_flags.vol;
            d.flt[free_idx]  = push_flags.flt;
            d.tag[free_idx]  = push_tag;
            d.addr[free_idx] = push_addr;
            d.seq[free_idx]  = push_seq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign full        = &q.vld;
    assign vol_pending = |(q.vld & q.vol);
    assign rel_mem     = found && !q.flt[sel];
    assign rel_flt     = found && q.flt[sel];
    assign rel_store   = q.st[sel];
    assign rel_addr    = q.addr[sel];
    assign rel_seq     = q.seq[sel];

    // checker state for the ordering and squash properties
    logic             chk_has_last_q, chk_sq_q;
    logic [SEQ_W-1:0] chk_last_seq_q;
    logic [TAG_W-1:0] chk_sq_tag_q;
    logic [DEPTH-1:0] stale;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_has_last_q <= 1'b0;
            chk_last_seq_q <= '0;
            chk_sq_q       <= 1'b0;
            chk_sq_tag_q   <= '0;
        end else begin
            if (found && q.vol[sel]) begin
                chk_has_last_q <= 1'b1;
                chk_last_seq_q <= q.seq[sel];
            end
            chk_sq_q     <= res_valid && res_squash;
            chk_sq_tag_q <= res_tag;
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            stale[i] = q.vld[i] && !q.conf[i] && (q.tag[i] == chk_sq_tag_q);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> free_found); // R7
    AST_ONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rel_onehot)); // R8
    AST_VOL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (found && q.vol[sel] && chk_has_last_q) |-> older(chk_last_seq_q, q.seq[sel])); // R5
    AST_SQUASH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        chk_sq_q |-> (stale == '0)); // R9

endmodule

// File: rtl/spec_issue_gate.sv
module spec_issue_gate
    import sig_pkg::*;
#(
    parameter int unsigned DEPTH     = 8,
    parameter int unsigned TAG_W     = 3,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned SEQ_W     = 8,
    parameter int unsigned PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_spec,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_uncached,
    input  logic              req_xlate_hit,
    input  logic [SEQ_W-1:0]  req_seq,
    input  logic              res_valid,
    input  logic              res_squash,
    input  logic [TAG_W-1:0]  res_tag,
    output logic              mem_valid,
    output logic              mem_store,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [SEQ_W-1:0]  mem_seq,
    output logic              flt_valid,
    output logic [SEQ_W-1:0]  flt_seq
);

    gate_act_e         act;
    req_flags_t        flags;
    logic              accept, pass_mem, pass_flt, push;
    logic              full, vol_pending;
    logic              rel_mem, rel_flt, rel_store;
    logic [ADDR_W-1:0] rel_addr;
    logic [SEQ_W-1:0]  rel_seq;

    sig_classify #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_class (
        .spec        (req_spec),
        .store       (req_store),
        .uncached    (req_uncached),
        .xlate_hit   (req_xlate_hit),
        .addr        (req_addr),
        .vol_pending (vol_pending),
        .act         (act),
        .flags       (flags)
    );

    always_comb begin
        req_ready = !full;
        accept    = req_valid && req_ready;
        pass_mem  = accept && (act == ACT_PASS);
        pass_flt  = accept && (act == ACT_FAULT);
        push      = accept && (act == ACT_HOLD);
    end

    sig_hold_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .push_conf   (!req_spec),
        .push_flags  (flags),
        .push_tag    (req_tag),
        .push_addr   (req_addr),
        .push_seq    (req_seq),
        .res_valid   (res_valid),
        .res_squash  (res_squash),
        .res_tag     (res_tag),
        .mem_busy    (pass_mem),
        .flt_busy    (pass_flt),
        .full        (full),
        .vol_pending (vol_pending),
        .rel_mem     (rel_mem),
        .rel_flt     (rel_flt),
        .rel_store   (rel_store),
        .rel_addr    (rel_addr),
        .rel_seq     (rel_seq)
    );

    always_comb begin
        mem_valid = pass_mem || rel_mem;
        mem_store = pass_mem ? req_store : rel_store;
        mem_addr  = pass_mem ? req_addr  : rel_addr;
        mem_seq   = pass_mem ? req_seq   : rel_seq;
        flt_valid = pass_flt || rel_flt;
        flt_seq   = pass_flt ? req_seq   : rel_seq;
    end

    AST_NO_SPEC_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_mem && req_spec) |-> !req_store); // R1
    AST_NO_SPEC_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_mem && req_spec) |-> !req_uncached); // R2
    AST_PORT_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_mem && rel_mem) && !(pass_flt && rel_flt)); // R8

endmodule

// File: tb/spec_issue_gate_bench.sv
`timescale 1ns/1ps
module spec_issue_gate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_spec = 1'b0, req_store = 1'b0;
    logic        req_uncached = 1'b0, req_xlate_hit = 1'b1;
    logic [2:0]  req_tag = '0, res_tag = '0;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_seq = '0;
    logic        res_valid = 1'b0, res_squash = 1'b0;
    logic        req_ready, mem_valid, mem_store, flt_valid;
    logic [31:0] mem_addr;
    logic [7:0]  mem_seq, flt_seq;

    always #2 clk = ~clk;

    spec_issue_gate u_spec_issue_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_spec(req_spec), .req_tag(req_tag), .req_store(req_store),
        .req_addr(req_addr), .req_uncached(req_uncached), .req_xlate_hit(req_xlate_hit),
        .req_seq(req_seq), .res_valid(res_valid), .res_squash(res_squash),
        .res_tag(res_tag), .mem_valid(mem_valid), .mem_store(mem_store),
        .mem_addr(mem_addr), .mem_seq(mem_seq), .flt_valid(flt_valid), .flt_seq(flt_seq)
    );

    int chk_n = 0, fail_n = 0;
    int mem_cnt = 0, flt_cnt = 0, log_n = 0;
    bit mon_clear = 0;
    logic [7:0] mem_log [16];
    logic [7:0] last_flt_seq;
    bit c_mem, c_flt, c_rdy, c_st;
    logic [7:0] c_mseq, c_fseq;

    // monitor: samples one time unit after each falling edge
    always @(negedge clk) begin
        #1;
        if (mon_clear) begin
            mem_cnt = 0; flt_cnt = 0; log_n = 0; mon_clear = 0;
        end
        if (mem_valid) begin
            if (log_n < 16) mem_log[log_n] = mem_seq;
            log_n++; mem_cnt++;
        end
        if (flt_valid) begin
            flt_cnt++; last_flt_seq = flt_seq;
        end
    end

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        chk_n++;
        if (!ok) begin
            fail_n++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // 0 = to memory, 1 = fault, 2 = parked
    function automatic int expect_cls(bit spec, bit st, bit unc, bit hit, logic [31:0] addr, bit volh);
        bit flt;
        flt = !st && (!hit || addr[31:12] == 20'd0);
        if (spec) return (st || unc || flt) ? 2 : 0;
        if (flt) return 1;
        if (unc && volh) return 2;
        return 0;
    endfunction

    task automatic send(input bit spec, input logic [2:0] tg, input bit st, input bit unc,
                        input bit hit, input logic [31:0] addr, input logic [7:0] sq);
        @(negedge clk);
        req_valid = 1; req_spec = spec; req_tag = tg; req_store = st;
        req_uncached = unc; req_xlate_hit = hit; req_addr = addr; req_seq = sq;
        #1;
        c_mem = mem_valid; c_flt = flt_valid; c_rdy = req_ready;
        c_mseq = mem_seq; c_fseq = flt_seq; c_st = mem_store;
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic resolve(input logic [2:0] tg, input bit squash);
        @(negedge clk);
        res_valid = 1; res_tag = tg; res_squash = squash;
        @(posedge clk); #1;
        res_valid = 0;
    endtask

    task automatic clear_mon();
        @(posedge clk); #1; mon_clear = 1;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 150000);
        chk(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        chk(req_ready == 1, "R7 reset ready", req_ready, 1);
        chk(mem_valid == 0 && flt_valid == 0, "R3 reset idle", mem_valid, 0);

        // R1: speculative store parked, then confirmed
        send(1, 3'd2, 1, 0, 1, 32'h0000_5000, 8'd21);
        chk(c_mem == 0, "R1 spec store not forwarded", c_mem, 0);
        resolve(3'd2, 0);
        @(negedge clk); #1;
        chk(mem_valid && mem_store && mem_seq == 8'd21, "R1 store released after confirm", mem_seq, 21);
        idle(2);

        // R2 + R3: speculative uncached load parked, then squashed
        clear_mon();
        send(1, 3'd1, 0, 1, 1, 32'h0000_6000, 8'd22);
        chk(c_mem == 0, "R2 uncached load not forwarded", c_mem, 0);
        resolve(3'd1, 1);
        idle(5);
        chk(mem_cnt == 0 && flt_cnt == 0, "R3 squashed entry never released", mem_cnt, 0);

        // R4: parked volatile load does not block a safe load
        send(1, 3'd1, 0, 1, 1, 32'h0000_7000, 8'd60);
        send(1, 3'd2, 0, 0, 1, 32'h0000_5000, 8'd61);
        chk(c_mem && c_mseq == 8'd61, "R4 safe spec load passes", c_mseq, 61);
        send(0, 3'd0, 1, 0, 1, 32'h0000_5004, 8'd62);
        chk(c_mem && c_mseq == 8'd62, "R4 non-spec store passes", c_mseq, 62);
        clear_mon();
        resolve(3'd1, 1);
        idle(4);
        chk(mem_cnt == 0, "R3 squash drops volatile load", mem_cnt, 0);

        // R5: volatile ordering across tags
        send(1, 3'd1, 0, 1, 1, 32'h0000_7000, 8'd70);
        send(1, 3'd2, 1, 1, 1, 32'h0000_7004, 8'd71);
        clear_mon();
        resolve(3'd2, 0);
        idle(3);
        chk(mem_cnt == 0, "R5 younger volatile waits for older", mem_cnt, 0);
        resolve(3'd1, 0);
        idle(4);
        chk(mem_cnt == 2 && mem_log[0] == 8'd70 && mem_log[1] == 8'd71, "R5 volatile order", mem_log[0], 70);

        // R5: non-speculative volatile queued behind a parked one
        send(1, 3'd3, 0, 1, 1, 32'h0000_7000, 8'd80);
        send(0, 3'd0, 0, 1, 1, 32'h0000_7008, 8'd81);
        chk(c_mem == 0, "R5 non-spec volatile not overtaking", c_mem, 0);
        clear_mon();
        resolve(3'd3, 0);
        idle(4);
        chk(mem_cnt == 2 && mem_log[0] == 8'd80 && mem_log[1] == 8'd81, "R5 queued non-spec volatile order", mem_log[1], 81);

        // R6: faulting loads
        send(1, 3'd2, 0, 0, 0, 32'h0000_9000, 8'd90);
        chk(c_mem == 0 && c_flt == 0, "R6 spec xlate miss parked", c_flt, 0);
        clear_mon();
        resolve(3'd2, 0);
        idle(3);
        chk(flt_cnt == 1 && last_flt_seq == 8'd90 && mem_cnt == 0, "R6 confirmed fault on fault port", last_flt_seq, 90);
        send(1, 3'd3, 0, 0, 1, 32'h0000_0100, 8'd91);
        chk(c_mem == 0 && c_flt == 0, "R6 spec page-zero load parked", c_mem, 0);
        clear_mon();
        resolve(3'd3, 1);
        idle(3);
        chk(flt_cnt == 0 && mem_cnt == 0, "R6 squashed fault silent", flt_cnt, 0);
        send(0, 3'd0, 0, 0, 0, 32'h0000_9000, 8'd92);
        chk(c_flt && c_fseq == 8'd92 && !c_mem, "R6 non-spec fault same cycle", c_fseq, 92);

        // R8: oldest first, one per cycle
        send(1, 3'd3, 1, 0, 1, 32'h0000_5000, 8'd100);
        send(1, 3'd4, 1, 0, 1, 32'h0000_5004, 8'd101);
        send(1, 3'd3, 1, 0, 1, 32'h0000_5008, 8'd102);
        clear_mon();
        resolve(3'd4, 0);
        idle(2);
        resolve(3'd3, 0);
        @(negedge clk); #1;
        chk(mem_valid && mem_seq == 8'd100, "R8 oldest released first", mem_seq, 100);
        @(negedge clk); #1;
        chk(mem_valid && mem_seq == 8'd102, "R8 next oldest on next cycle", mem_seq, 102);
        idle(2);
        chk(mem_cnt == 3 && mem_log[0] == 8'd101, "R8 release count", mem_cnt, 3);

        // R7: fill the queue
        for (int k = 0; k < 8; k++) send(1, 3'd5, 1, 0, 1, 32'h0000_5000, 8'(110 + k));
        @(negedge clk); #1;
        chk(req_ready == 0, "R7 ready low when full", req_ready, 0);
        send(1, 3'd6, 1, 0, 1, 32'h0000_5000, 8'd118);
        chk(c_rdy == 0, "R7 request refused when full", c_rdy, 0);
        clear_mon();
        resolve(3'd5, 0);
        idle(10);
        chk(req_ready == 1 && mem_cnt == 8, "R7 drained and ready again", mem_cnt, 8);

        // R9: squash one tag, keep the other
        send(1, 3'd6, 1, 0, 1, 32'h0000_5000, 8'd130);
        send(1, 3'd6, 0, 1, 1, 32'h0000_7000, 8'd131);
        send(1, 3'd7, 1, 0, 1, 32'h0000_5004, 8'd132);
        send(1, 3'd6, 1, 0, 1, 32'h0000_5008, 8'd133);
        clear_mon();
        resolve(3'd6, 1);
        resolve(3'd7, 0);
        idle(4);
        chk(mem_cnt == 1 && mem_log[0] == 8'd132, "R9 only other tag released", mem_cnt, 1);

        // random rounds
        begin
            logic [7:0] sq;
            sq = 8'd140;
            for (int r = 0; r < 40; r++) begin
                int hm[3], hf[3], em, ef, k;
                bit volh;
                hm = '{0, 0, 0}; hf = '{0, 0, 0}; volh = 0; em = 0; ef = 0;
                k = 1 + int'($urandom % 3);
                for (int i = 0; i < k; i++) begin
                    bit sp, st, un, ht, fl;
                    int tg, cls;
                    logic [31:0] ad;
                    sp = $urandom % 2; st = ($urandom % 4) == 0; un = ($urandom % 3) == 0;
                    ht = ($urandom % 5) != 0;
                    ad = (($urandom % 4) == 0) ? 32'($urandom % 4096) : 32'($urandom);
                    tg = 1 + int'($urandom % 2);
                    if (!sp && un && volh) un = 0;
                    cls = expect_cls(sp, st, un, ht, ad, volh);
                    send(sp, 3'(tg), st, un, ht, ad, sq);
                    chk(c_mem == (cls == 0) && c_flt == (cls == 1), "R4 R6 random classification", c_mem, cls == 0);
                    fl = !st && (!ht || ad[31:12] == 20'd0);
                    if (cls == 2) begin
                        if (fl) hf[tg]++; else hm[tg]++;
                        if (un && !fl) volh = 1;
                    end
                    sq = sq + 8'd1;
                end
                clear_mon();
                for (int t = 1; t <= 2; t++) begin
                    bit sqz;
                    sqz = $urandom % 2;
                    if (!sqz) begin em += hm[t]; ef += hf[t]; end
                    resolve(3'(t), sqz);
                end
                idle(12);
                chk(mem_cnt == em, "R3 random memory releases", mem_cnt, em);
                chk(flt_cnt == ef, "R6 random fault releases", flt_cnt, ef);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
        $finish;
    end

endmodule